// File: doc/BRIEF.md
# Address-Filtering Asynchronous Serial Receiver

This block receives asynchronous serial characters on a single input line. It samples the line sixteen times per bit, checks each start bit at its middle, gathers the data bits least significant first, optionally gathers one extra address-marker bit, and then checks the stop bit. Each finished character moves from the shift register into a holding data register, and a set of status flags reports the result.

On a shared line, many receivers hear the same traffic. Software sets a wake-up enable bit so that the block ignores every character until one arrives with its address-marker bit equal to 1. That character is treated as an address. It is delivered, and the wake-up enable bit clears itself in hardware, so the data characters that follow are delivered as well. Software reads the address and decides whether to keep listening or to set wake-up enable again. The interface is a control write port, a write-one-to-clear port for the status flags, read-only views of control, status and data, and two level interrupt outputs.

Top module: `mpuart_rx`

## Requirements
- R1: A new character is accepted only if the line is low at a tick while control bit 0 (receive enable) is 1. While receive enable is 0, frames on the line change neither the data register nor the status flags.
- R2: Writing receive enable to 0 leaves all status flags at their previous values.
- R3: Control bit 1 (wake-up enable) acts only while control bit 2 (address format) is 1. With address format at 0, no marker bit is framed, and characters are delivered normally even if wake-up enable is 1.
- R4: While wake-up enable and address format are both 1, a character whose marker bit is 0 changes neither the data register nor any status flag, and no error is detected for it.
- R5: While wake-up enable and address format are both 1, both interrupt outputs stay 0.
- R6: When a character with marker bit 1 completes while wake-up filtering is active, wake-up enable clears to 0 and the character is handled normally. For a loaded character, status bit 3 (marker flag) takes that character's marker bit.
- R7: A start bit is confirmed by a low sample at mid-bit. Data bits are taken least significant first, each at its mid-bit sample. A stop bit sampled as 0 sets status bit 1 (framing error) and does not load the data register.
- R8: If a character completes while status bit 0 (receive full) is 1, status bit 2 (overrun) is set and the data register keeps its old contents.
- R9: A good character that completes while receive full is 0 loads the data register and sets receive full.
- R10: The receive interrupt is receive full AND control bit 3. The error interrupt is (framing error OR overrun) AND control bit 4.
- R11: Writing a mask to the status clear port clears each flag whose mask bit is 1. Mask bit positions match the status bits.
- R12: After reset, the control bits, the status flags, the data register and both interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idle high |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 5 | Control value: rx_en, wake_en, addr_fmt, rie, eie (bits 0..4) |
| sts_clr_we | input | 1 | Strobe for the status clear port |
| sts_clr_mask | input | 4 | Status bits to clear, 1 = clear |
| ctl_o | output | 5 | Current control register |
| sts_o | output | 4 | Status: full, framing error, overrun, marker (bits 0..3) |
| rx_data_o | output | DATA_W | Holding data register |
| rx_irq_o | output | 1 | Receive interrupt |
| err_irq_o | output | 1 | Error interrupt |

## Verification
The bench builds the block with CLK_DIV set to 2, so one bit lasts 32 clocks and a full character with its marker bit fits in about 350 cycles. This allows more than a dozen frames in a short run. These frames cover an address arriving while characters are filtered, the overrun that follows it, a marker character with a bad stop bit, wake-up enable with the address format off, and a frame sent while reception is disabled. DATA_W and the oversampling ratio stay at their defaults of 8 and 16.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;

    typedef struct packed {
        logic eie;
        logic rie;
        logic addr_fmt;
        logic wake_en;
        logic rx_en;
    } ctl_t;

    typedef struct packed {
        logic mark;
        logic ovr;
        logic ferr;
        logic full;
    } sts_t;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_MARK,
        FR_STOP
    } fr_state_e;

endpackage

// File: rtl/mpuart_baud.sv
module mpuart_baud #(
    parameter int CLK_DIV = 27
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } baud_t;

    baud_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (st_q.cnt == LAST) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;
endmodule

// File: rtl/mpuart_sync.sv
module mpuart_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = din;
        for (int i = 1; i < STAGES; i++) sh_d[i] = sh_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/mpuart_frame.sv
module mpuart_frame
    import mpuart_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic              rx_en,
    input  logic              addr_fmt,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              mark_o,
    output logic              stop_ok_o,
    output logic              idle_o
);
    localparam int OW = $clog2(OVS);
    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [OW-1:0] HALF_LAST = OW'(OVS / 2 - 1);
    localparam logic [OW-1:0] FULL_LAST = OW'(OVS - 1);
    localparam logic [IW-1:0] IDX_LAST  = IW'(DATA_W - 1);

    typedef struct packed {
        fr_state_e         st;
        logic [OW-1:0]     cnt;
        logic [IW-1:0]     idx;
        logic [DATA_W-1:0] sh;
        logic              fmt;
        logic              mark;
        logic              stop_ok;
        logic              done;
    } fr_t;

    fr_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (tick) begin
            unique case (st_q.st)
                FR_IDLE: begin
                    if (!rxd && rx_en) begin
                        st_d.st   = FR_START;
                        st_d.cnt  = '0;
                        st_d.fmt  = addr_fmt;
                        st_d.mark = 1'b0;
                    end
                end
                FR_START: begin
                    if (st_q.cnt == HALF_LAST) begin
                        st_d.cnt = '0;
                        st_d.idx = '0;
                        st_d.st  = rxd ? FR_IDLE : FR_DATA;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                FR_DATA: begin
                    if (st_q.cnt == FULL_LAST) begin
                        st_d.cnt = '0;
                        st_d.sh  = {rxd, st_q.sh[DATA_W-1:1]};
                        if (st_q.idx == IDX_LAST)
                            st_d.st = st_q.fmt ? FR_MARK : FR_STOP;
                        else
                            st_d.idx = st_q.idx + 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                FR_MARK: begin
                    if (st_q.cnt == FULL_LAST) begin
                        st_d.cnt  = '0;
                        st_d.mark = rxd;
                        st_d.st   = FR_STOP;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                FR_STOP: begin
                    if (st_q.cnt == FULL_LAST) begin
                        st_d.cnt     = '0;
                        st_d.stop_ok = rxd;
                        st_d.done    = 1'b1;
                        st_d.st      = FR_IDLE;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: st_d.st = FR_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.st      <= FR_IDLE;
            st_q.stop_ok <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o    = st_q.done;
    assign data_o    = st_q.sh;
    assign mark_o    = st_q.mark;
    assign stop_ok_o = st_q.stop_ok;
    assign idle_o    = (st_q.st == FR_IDLE);
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
    import mpuart_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int CLK_DIV     = 27,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic              ctl_we,
    input  logic [4:0]        ctl_wdata,
    input  logic              sts_clr_we,
    input  logic [3:0]        sts_clr_mask,
    output logic [4:0]        ctl_o,
    output logic [3:0]        sts_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_irq_o,
    output logic              err_irq_o
);
    typedef struct packed {
        ctl_t              ctl;
        sts_t              sts;
        logic [DATA_W-1:0] data;
        logic              rx_irq;
        logic              err_irq;
    } reg_t;

    reg_t st_d, st_q;

    logic              tick;
    logic              rxd;
    logic              frm_done;
    logic [DATA_W-1:0] frm_data;
    logic              frm_mark;
    logic              frm_stop_ok;
    logic              frm_idle;
    logic              wake_act;
    logic              wake_nxt;
    logic              drop;

    mpuart_baud #(.CLK_DIV(CLK_DIV)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    mpuart_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_i),
        .dout  (rxd)
    );

    mpuart_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rxd       (rxd),
        .rx_en     (st_q.ctl.rx_en),
        .addr_fmt  (st_q.ctl.addr_fmt),
        .done_o    (frm_done),
        .data_o    (frm_data),
        .mark_o    (frm_mark),
        .stop_ok_o (frm_stop_ok),
        .idle_o    (frm_idle)
    );

    assign wake_act = st_q.ctl.wake_en & st_q.ctl.addr_fmt;
    assign drop     = wake_act & ~frm_mark;

    always_comb begin
        st_d = st_q;
        if (ctl_we)     st_d.ctl = ctl_t'(ctl_wdata);
        if (sts_clr_we) st_d.sts = st_d.sts & ~sts_t'(sts_clr_mask);
        if (frm_done && !drop) begin
            if (wake_act) st_d.ctl.wake_en = 1'b0;
            if (st_d.sts.full) begin
                st_d.sts.ovr = 1'b1;
                if (!frm_stop_ok) st_d.sts.ferr = 1'b1;
            end else if (!frm_stop_ok) begin
                st_d.sts.ferr = 1'b1;
            end else begin
                st_d.data     = frm_data;
                st_d.sts.full = 1'b1;
                st_d.sts.mark = frm_mark;
            end
        end
        wake_nxt     = st_d.ctl.wake_en & st_d.ctl.addr_fmt;
        st_d.rx_irq  = st_d.sts.full & st_d.ctl.rie & ~wake_nxt;
        st_d.err_irq = (st_d.sts.ferr | st_d.sts.ovr) & st_d.ctl.eie & ~wake_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl_o     = st_q.ctl;
    assign sts_o     = st_q.sts;
    assign rx_data_o = st_q.data;
    assign rx_irq_o  = st_q.rx_irq;
    assign err_irq_o = st_q.err_irq;
endmodule

// File: rtl/mpuart_rx_chk.sv
module mpuart_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_we,
    input logic [4:0]        ctl_wdata,
    input logic              sts_clr_we,
    input logic [4:0]        ctl_o,
    input logic [3:0]        sts_o,
    input logic [DATA_W-1:0] rx_data_o,
    input logic              rx_irq_o,
    input logic              err_irq_o,
    input logic              frm_done,
    input logic              frm_mark,
    input logic              frm_stop_ok,
    input logic              frm_idle
);
    logic wk;
    assign wk = ctl_o[1] & ctl_o[2];

    p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frm_idle && !ctl_o[0] |=> frm_idle);

    p_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we && !ctl_wdata[0] && !sts_clr_we && !frm_done |=> $stable(sts_o));

    p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done && wk && !frm_mark && !ctl_we && !sts_clr_we
        |=> $stable(rx_data_o) && $stable(sts_o) && $stable(ctl_o));

    p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wk |-> !rx_irq_o && !err_irq_o);

    p_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done && wk && frm_mark && !ctl_we |=> !ctl_o[1]);

    p_ferr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done && !frm_stop_ok && !(wk && !frm_mark) && !sts_clr_we |=> sts_o[1]);

    p_ovr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done && sts_o[0] && !(wk && !frm_mark) && !sts_clr_we
        |=> sts_o[2] && $stable(rx_data_o));
endmodule

bind mpuart_rx mpuart_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_we      (ctl_we),
    .ctl_wdata   (ctl_wdata),
    .sts_clr_we  (sts_clr_we),
    .ctl_o       (ctl_o),
    .sts_o       (sts_o),
    .rx_data_o   (rx_data_o),
    .rx_irq_o    (rx_irq_o),
    .err_irq_o   (err_irq_o),
    .frm_done    (frm_done),
    .frm_mark    (frm_mark),
    .frm_stop_ok (frm_stop_ok),
    .frm_idle    (frm_idle)
);

// File: tb/sim_mpuart_rx.sv
`timescale 1ns/1ps
module sim_mpuart_rx;
    localparam int DW   = 8;
    localparam int DIV  = 2;
    localparam int BITC = DIV * 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_i = 1'b1;
    logic          ctl_we = 1'b0;
    logic [4:0]    ctl_wdata = '0;
    logic          sts_clr_we = 1'b0;
    logic [3:0]    sts_clr_mask = '0;
    logic [4:0]    ctl_o;
    logic [3:0]    sts_o;
    logic [DW-1:0] rx_data_o;
    logic          rx_irq_o;
    logic          err_irq_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [4:0] cur_ctl = '0;

    always #10 clk = ~clk;

    mpuart_rx #(.DATA_W(DW), .CLK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .sts_clr_we(sts_clr_we), .sts_clr_mask(sts_clr_mask),
        .ctl_o(ctl_o), .sts_o(sts_o), .rx_data_o(rx_data_o),
        .rx_irq_o(rx_irq_o), .err_irq_o(err_irq_o)
    );

    typedef struct packed {
        logic       cw;
        logic [4:0] ctl;
        logic       clr;
        logic [7:0] dat;
        logic       mp;
        logic       stp;
        logic [7:0] xd;
        logic [3:0] xs;
        logic [4:0] xc;
        logic       xri;
        logic       xei;
    } vec_t;

    // ctl: 1 rx_en, 2 wake_en, 4 addr_fmt, 8 rie, 16 eie
    // sts: 1 full, 2 framing error, 4 overrun, 8 marker
    localparam vec_t VEC [8] = '{
        '{1'b1, 5'h0F, 1'b1, 8'h55, 1'b0, 1'b1, 8'h00, 4'h0, 5'h0F, 1'b0, 1'b0}, // R4 filtered
        '{1'b0, 5'h0F, 1'b0, 8'hA3, 1'b1, 1'b1, 8'hA3, 4'h9, 5'h0D, 1'b1, 1'b0}, // R6 address wakes
        '{1'b0, 5'h0D, 1'b0, 8'h3C, 1'b0, 1'b1, 8'hA3, 4'hD, 5'h0D, 1'b1, 1'b0}, // R8 overrun
        '{1'b1, 5'h0F, 1'b1, 8'h11, 1'b0, 1'b1, 8'hA3, 4'h0, 5'h0F, 1'b0, 1'b0}, // R4 filtered again
        '{1'b0, 5'h0F, 1'b0, 8'h22, 1'b1, 1'b0, 8'hA3, 4'h2, 5'h0D, 1'b0, 1'b0}, // R7 marker char, bad stop
        '{1'b1, 5'h1D, 1'b1, 8'h7E, 1'b0, 1'b1, 8'h7E, 4'h1, 5'h1D, 1'b1, 1'b0}, // R9 normal load
        '{1'b1, 5'h0B, 1'b1, 8'hC4, 1'b0, 1'b1, 8'hC4, 4'h1, 5'h0B, 1'b1, 1'b0}, // R3 wake ignored
        '{1'b1, 5'h0E, 1'b1, 8'h99, 1'b0, 1'b1, 8'hC4, 4'h0, 5'h0E, 1'b0, 1'b0}  // R1 receive disabled
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [4:0] v);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = v; cur_ctl = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic clr_sts(input logic [3:0] m);
        @(negedge clk);
        sts_clr_we = 1'b1; sts_clr_mask = m;
        @(negedge clk);
        sts_clr_we = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input logic mp, input logic stp);
        @(negedge clk);
        rx_i = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_i = d[i];
            repeat (BITC) @(negedge clk);
        end
        if (cur_ctl[2]) begin
            rx_i = mp;
            repeat (BITC) @(negedge clk);
        end
        rx_i = stp;
        repeat (BITC) @(negedge clk);
        rx_i = 1'b1;
        repeat (BITC) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R12 ctl", 32'(ctl_o), 0);
        chk("R12 sts", 32'(sts_o), 0);
        chk("R12 data", 32'(rx_data_o), 0);
        chk("R12 irqs", {30'd0, rx_irq_o, err_irq_o}, 0);

        for (int k = 0; k < 8; k++) begin
            if (VEC[k].cw)  wr_ctl(VEC[k].ctl);
            if (VEC[k].clr) clr_sts(4'hF);
            send(VEC[k].dat, VEC[k].mp, VEC[k].stp);
            chk($sformatf("vec%0d data R4/R8/R9", k), 32'(rx_data_o), 32'(VEC[k].xd));
            chk($sformatf("vec%0d sts R6/R7", k), 32'(sts_o), 32'(VEC[k].xs));
            chk($sformatf("vec%0d ctl R6/R3", k), 32'(ctl_o), 32'(VEC[k].xc));
            chk($sformatf("vec%0d irq R10/R5", k), {30'd0, rx_irq_o, err_irq_o},
                {30'd0, VEC[k].xri, VEC[k].xei});
        end

        // R7 / R10: bad stop with error interrupt enabled
        wr_ctl(5'h1D);
        clr_sts(4'hF);
        send(8'h5A, 1'b0, 1'b0);
        chk("R7 ferr sts", 32'(sts_o), 32'h2);
        chk("R7 no load", 32'(rx_data_o), 32'hC4);
        chk("R10 err irq", {30'd0, rx_irq_o, err_irq_o}, 32'h1);

        // R2: disabling reception keeps the flags
        wr_ctl(5'h1C);
        repeat (4) @(negedge clk);
        chk("R2 flags kept", 32'(sts_o), 32'h2);
        chk("R2 irq kept", 32'(err_irq_o), 1);

        // R11: write-one-to-clear
        clr_sts(4'h2);
        chk("R11 cleared", 32'(sts_o), 0);
        chk("R11 irq low", 32'(err_irq_o), 0);

        // R5: enabling the wake filter masks a pending receive interrupt
        wr_ctl(5'h1D);
        send(8'h66, 1'b0, 1'b1);
        chk("R9 load 66", 32'(rx_data_o), 32'h66);
        chk("R10 rx irq", 32'(rx_irq_o), 1);
        wr_ctl(5'h1F);
        chk("R5 rx irq masked", 32'(rx_irq_o), 0);
        chk("R5 flags held", 32'(sts_o), 32'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule